// File: doc/BRIEF.md
# Dual-Source Programmable Clock Output Divider

This block turns three one-byte control registers into three divided clock outputs. Each channel picks a slow source (a 32768 Hz reference) or a fast source (around 4 MHz). It applies a pre-divider only on the fast path, then a power-of-two post-divider, and gates the result with an enable bit. The block runs on one system clock `clk`. Each source is presented as a strobe input that pulses once per source clock edge, which is twice per source period. A total divide ratio N therefore toggles the output once every N strobe pulses. The output period is N source periods and the duty cycle is 50%.

Software writes and reads the registers through a plain byte port whose address selects the channel. A new setting never cuts a pulse short. While a channel runs, its counters keep the setting they were started with until the output next falls. The register contents are adopted at that falling edge. Clearing the enable bit stops the channel at once.

Top module: `clkout_divider`

## Requirements
- R1: Channels 0, 1 and 2 each own one byte register at addresses 0, 1 and 2. All registers reset to 0x00. `rdata` shows the register at `addr` one clock after `addr` is presented. A write to address 3 changes no register, and reading address 3 returns 0x00.
- R2: Register bit 0 is the enable. While it is 0, the channel output is low, starting in the second clock after the write and for as long as the bit stays 0. The other bits still read back as written.
- R3: When bit 4 (source select) is 0, the channel counts `slow_edge` pulses. The output toggles every 2^P pulses, where P is the post-divider code in bits 3:1.
- R4: When bit 4 is 0, the pre-divider code in bits 7:5 has no effect on the output period.
- R5: When bit 4 is 1, the channel counts `fast_edge` pulses. Pre-divider codes 0 to 6 give a pre-ratio of 1, 2, 4, 8, 16, 32 or 64.
- R6: Pre-divider code 7 gives a ratio of 122. The high and low phases each last exactly 122 fast pulses, so the duty cycle is 50%.
- R7: With the fast source, the output toggles every (pre-ratio × 2^P) pulses.
- R8: A register change made while the channel runs takes effect at the next falling edge of the output. The high phase in progress completes at the old length. If the write lands in the same clock as a falling edge, the old setting runs through one more low and high phase.
- R9: The three channels run independently. Writing one channel does not disturb the phases of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Register address (channel number) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| slow_edge | input | 1 | One pulse per edge of the 32768 Hz source |
| fast_edge | input | 1 | One pulse per edge of the fast source |
| clk_out | output | NUM_CH | Divided and gated clock outputs, one bit per channel |

## Verification
Two events can fall in the same clock: a register write to a running channel, and the falling edge at which that channel adopts its register. The bench runs a channel at ratio 1 on the slow strobe. It waits for a clock in which the output is high and a slow pulse is due, then asserts the write in exactly that clock. The expected result is one more full low phase and one more high phase at the old length, then a low phase at the new length. The bench also writes a channel in the middle of a high phase and checks that this phase keeps its original length.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int PRE_W      = 3;
  localparam int POST_W     = 3;
  localparam int PRE_LAST   = 122;
  localparam int RATIO_W    = $clog2(PRE_LAST + 1);
  localparam int POST_CNT_W = (1 << POST_W) - 1;

  // Field order follows the register bit layout, MSB first.
  typedef struct packed {
    logic [PRE_W-1:0]  pre;
    logic              sel;
    logic [POST_W-1:0] post;
    logic              en;
  } cdiv_cfg_t;

  localparam int CFG_W = $bits(cdiv_cfg_t);

  // Pre-divider ratio: powers of two, except the all-ones code.
  function automatic logic [RATIO_W-1:0] pre_ratio(input logic [PRE_W-1:0] code);
    if (code == {PRE_W{1'b1}})
      return RATIO_W'(PRE_LAST);
    else
      return RATIO_W'(1) << code;
  endfunction

endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CFG_W-1:0]         wdata,
  output logic [CFG_W-1:0]         rdata,
  output cdiv_cfg_t [NUM_CH-1:0]   cfg
);

  localparam logic [ADDR_W:0] CH_LIM = (ADDR_W + 1)'(NUM_CH);

  cdiv_cfg_t [NUM_CH-1:0] cfg_q;
  logic                   hit;

  assign hit = ({1'b0, addr} < CH_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en && hit) begin
      cfg_q[addr] <= cdiv_cfg_t'(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (hit)
      rdata <= cfg_q[addr];
    else
      rdata <= '0;
  end

  assign cfg = cfg_q;

  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit) |=> $stable(cfg_q)); // R1

endmodule

// File: rtl/cdiv_prescale.sv
module cdiv_prescale
  import cdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratio,
  output logic               pulse
);

  logic [RATIO_W-1:0] cnt_q;
  logic               last;

  assign last  = (cnt_q == ratio - RATIO_W'(1));
  assign pulse = tick && last;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= last ? '0 : cnt_q + RATIO_W'(1);
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (!clr && ratio != '0) |-> (cnt_q < ratio)); // R5

endmodule

// File: rtl/cdiv_channel.sv
module cdiv_channel
  import cdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cdiv_cfg_t cfg,
  input  logic      slow_edge,
  input  logic      fast_edge,
  output logic      clk_out
);

  cdiv_cfg_t              act_q;
  logic [POST_CNT_W-1:0]  post_q;
  logic [POST_CNT_W-1:0]  post_last;
  logic [RATIO_W-1:0]     ratio;
  logic                   out_q;
  logic                   src_edge;
  logic                   run;
  logic                   pre_pulse;
  logic                   toggle;

  always_comb begin
    src_edge  = act_q.sel ? fast_edge : slow_edge;
    ratio     = act_q.sel ? pre_ratio(act_q.pre) : RATIO_W'(1);
    run       = cfg.en && act_q.en;
    post_last = POST_CNT_W'((1 << act_q.post) - 1);
    toggle    = pre_pulse && (post_q == post_last);
  end

  cdiv_prescale u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (!run),
    .tick  (src_edge),
    .ratio (ratio),
    .pulse (pre_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      post_q <= '0;
      out_q  <= 1'b0;
    end else if (!run) begin
      act_q  <= cfg;
      post_q <= '0;
      out_q  <= 1'b0;
    end else if (pre_pulse) begin
      if (toggle) begin
        post_q <= '0;
        out_q  <= ~out_q;
        if (out_q)
          act_q <= cfg;
      end else begin
        post_q <= post_q + POST_CNT_W'(1);
      end
    end
  end

  assign clk_out = out_q;

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |=> !out_q); // R2

  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> $past(src_edge)); // R3

  AST_SWAP_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    ($past(act_q.en) && act_q.en && !$stable(act_q)) |-> !out_q); // R8

  AST_POST_RANGE: assert property (@(posedge clk) disable iff (rst)
    post_q <= post_last); // R7

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import cdiv_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              slow_edge,
  input  logic              fast_edge,
  output logic [NUM_CH-1:0] clk_out
);

  cdiv_cfg_t [NUM_CH-1:0] cfg_all;

  cdiv_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .cfg   (cfg_all)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cdiv_channel u_ch (
      .clk       (clk),
      .rst       (rst),
      .cfg       (cfg_all[g]),
      .slow_edge (slow_edge),
      .fast_edge (fast_edge),
      .clk_out   (clk_out[g])
    );
  end

endmodule

// File: tb/sim_clkout_divider.sv
`timescale 1ns/1ps
module sim_clkout_divider;

  localparam int SLOW_T = 4;
  localparam int FAST_T = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       slow_edge;
  logic       fast_edge;
  logic [2:0] clk_out;
  logic [15:0] tcnt = '0;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  initial forever @(posedge clk) tcnt <= tcnt + 16'd1;
  assign slow_edge = (tcnt[1:0] == 2'd0);
  assign fast_edge = (tcnt[0] == 1'b0);

  clkout_divider u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .slow_edge(slow_edge), .fast_edge(fast_edge),
    .clk_out(clk_out)
  );

  function automatic logic [7:0] mk(int pre, int sel, int post, int en);
    return {3'(pre), 1'(sel), 3'(post), 1'(en)};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    wr_en = 1'b0; addr = 2'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_change(int ch, output int n);
    logic v;
    v = clk_out[ch];
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (clk_out[ch] == v && n < 40000);
  endtask

  task automatic wait_high(int ch);
    int n;
    n = 0;
    while (clk_out[ch] != 1'b1 && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(int ch, logic [7:0] cv, int exp, string tag);
    int hi, lo;
    wr(ch, 8'h00);
    wr(ch, cv);
    wait_high(ch);
    wait_change(ch, hi);
    wait_change(ch, lo);
    chk(hi == exp, {tag, " high"}, hi, exp);
    chk(lo == exp, {tag, " low"}, lo, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int a, b, c;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      rd(i, d);
      chk(d == 8'h00, "R1 reset value", d, 0);
    end
    chk(clk_out == 3'b000, "R2 outputs low after reset", clk_out, 0);

    // R1 readback and unused address
    wr(0, 8'hA4); wr(1, 8'h3C); wr(2, 8'h7E); wr(3, 8'hFF);
    rd(0, d); chk(d == 8'hA4, "R1 readback ch0", d, 8'hA4);
    rd(1, d); chk(d == 8'h3C, "R1 readback ch1", d, 8'h3C);
    rd(2, d); chk(d == 8'h7E, "R1 readback ch2", d, 8'h7E);
    rd(3, d); chk(d == 8'h00, "R1 unused address", d, 0);
    chk(clk_out == 3'b000, "R2 disabled channels low", clk_out, 0);
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);

    // R3 slow source, post-divider sweep
    for (int p = 0; p < 8; p++)
      measure(2, mk(0, 0, p, 1), (1 << p) * SLOW_T, $sformatf("R3 slow post=%0d", p));

    // R4 pre-divider ignored on slow source
    measure(1, mk(7, 0, 1, 1), 2 * SLOW_T, "R4 slow pre=7");
    measure(1, mk(3, 0, 2, 1), 4 * SLOW_T, "R4 slow pre=3");

    // R5 / R6 fast source, pre-divider sweep
    for (int q = 0; q < 7; q++)
      measure(0, mk(q, 1, 0, 1), (1 << q) * FAST_T, $sformatf("R5 fast pre=%0d", q));
    measure(0, mk(7, 1, 0, 1), 122 * FAST_T, "R6 fast pre=7 duty");

    // R7 combined ratios
    measure(0, mk(7, 1, 2, 1), 122 * 4 * FAST_T, "R7 pre=7 post=2");
    measure(0, mk(3, 1, 3, 1), 8 * 8 * FAST_T, "R7 pre=3 post=3");

    // R2 disable holds output low, bits still readable
    measure(1, mk(0, 0, 0, 1), SLOW_T, "R2 pre-disable run");
    wr(1, mk(5, 1, 6, 0));
    @(negedge clk);
    a = 0;
    for (int i = 0; i < 200; i++) begin
      if (clk_out[1]) a++;
      @(negedge clk);
    end
    chk(a == 0, "R2 output held low while disabled", a, 0);
    rd(1, d); chk(d == 8'hBC, "R2 readback while disabled", d, 8'hBC);

    // R8 write in the same clock as a falling edge
    measure(0, mk(0, 0, 0, 1), SLOW_T, "R8 setup");
    a = 0;
    while (!(clk_out[0] && slow_edge) && a < 100) begin
      @(negedge clk);
      a++;
    end
    wr_en = 1'b1; addr = 2'd0; wdata = mk(0, 0, 2, 1);
    @(negedge clk);
    wr_en = 1'b0;
    wait_change(0, a);
    wait_change(0, b);
    wait_change(0, c);
    chk(a == SLOW_T, "R8 old low phase after coincident write", a, SLOW_T);
    chk(b == SLOW_T, "R8 old high phase after coincident write", b, SLOW_T);
    chk(c == 4 * SLOW_T, "R8 new low phase", c, 4 * SLOW_T);

    // R8 write in the middle of a high phase
    wait_high(0);
    wr(0, mk(0, 0, 0, 1));
    wait_change(0, a);
    wait_change(0, b);
    chk(a + 2 == 4 * SLOW_T, "R8 high phase keeps old length", a + 2, 4 * SLOW_T);
    chk(b == SLOW_T, "R8 next low uses new setting", b, SLOW_T);

    // R9 independent channels
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
    wr(0, mk(0, 0, 1, 1));
    wr(1, mk(2, 1, 1, 1));
    wr(2, mk(7, 1, 0, 1));
    measure(1, mk(2, 1, 1, 1), 8 * FAST_T, "R9 ch1 alongside others");
    measure(2, mk(7, 1, 0, 1), 122 * FAST_T, "R9 ch2 alongside others");
    wait_high(0);
    wait_change(0, a);
    wait_change(0, b);
    chk(a == 2 * SLOW_T, "R9 ch0 high undisturbed", a, 2 * SLOW_T);
    chk(b == 2 * SLOW_T, "R9 ch0 low undisturbed", b, 2 * SLOW_T);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule